// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

The block is a watchdog counter behind a small 16-bit register-write port. Software chooses a timeout in half-second steps, sets the enable bit, and from then on must feed the counter with an ordered pair of writes to the service register. When the countdown reaches its end without a feed, the block pulses a reset output for one tick period and latches the cause in a status flag. A prescaled half-second `tick` input drives the countdown. A `lowpower` input freezes it when software has allowed that.

The countdown is held in a three-state machine. OFF moves to RUN when the enable bit is seen. RUN moves to FIRE on expiry when the reset output is allowed, and back to OFF on expiry when it is not. FIRE moves to OFF on the next tick. The key detector is a two-state machine. IDLE moves to ARMED on the first key. ARMED moves back to IDLE on the second key, which reloads the counter, or on any other value. ARMED stays ARMED on a repeated first key. The read port is combinational on `addr`.

Top module: `wdog_keyed`

## Requirements
- R1: After power-on reset, the control word (offset 0x00) and the status word (offset 0x04) read 0x0000, and `wd_rst` is low.
- R2: A timeout field value T (control bits 15:8) gives an expiry on the (T+1)-th tick after the enable bit (bit 2) is set or after a reload. A field of 2*s-1 therefore means s seconds.
- R3: Writing 0x5555 and then 0xAAAA to the service word (offset 0x02) reloads the counter from the timeout field. The reverse order does not reload it.
- R4: In the armed state, any service write other than 0x5555 or 0xAAAA returns the detector to idle without a reload. A repeated 0x5555 keeps it armed.
- R5: Software cannot clear the enable bit. A write of 0 to bit 2 while running leaves it reading 1, and the countdown continues.
- R6: The suspend-permit bit (bit 0) takes its value from the first control write after power-on. Later writes leave it unchanged.
- R7: A new timeout field written while running does not change the countdown in progress. It is used from the next reload.
- R8: On expiry with reset allowed (bit 3 = 0), `wd_rst` goes high at that tick and drops at the following tick.
- R9: An expiry that pulses `wd_rst` sets status bit 1 (the status word reads 0x0002). The bit stays set until power-on reset.
- R10: An expiry clears the enable bit and returns the counter to OFF. No further pulse occurs without a new enable.
- R11: While bit 0 is 1 and `lowpower` is high, ticks do not advance the countdown. With bit 0 at 0, `lowpower` has no effect.
- R12: With bit 3 = 1, an expiry gives no pulse on `wd_rst` and leaves the status flag at 0, but still clears the enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset |
| tick | input | 1 | Half-second count strobe, one clock wide |
| lowpower | input | 1 | Low-power indication from the system |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Byte offset of the register |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr`, combinational |
| wd_rst | output | 1 | Watchdog reset pulse |

## Verification
A wrong count or an early load shows up as `wd_rst` rising one or more ticks away from the (T+1)-th tick. The bench therefore samples the output after every tick that lies near the boundary. A key detector left in the wrong state turns a rejected key sequence into a reload, or a valid one into a non-reload, so the pulse moves by several ticks on the very next expiry. Faults in the sticky enable bit, the write-once bit and the cause flag are visible on the read port in the cycle after the write or the expiry.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int REG_W   = 16;
    localparam int TMO_W   = 8;
    localparam int ADDR_W  = 3;

    localparam logic [ADDR_W-1:0] OFF_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFF_SVC  = 3'd2;
    localparam logic [ADDR_W-1:0] OFF_STAT = 3'd4;

    localparam int BIT_SUSP  = 0;
    localparam int BIT_EN    = 2;
    localparam int BIT_NORST = 3;
    localparam int TMO_LSB   = 8;
    localparam int BIT_CAUSE = 1;

    localparam logic [REG_W-1:0] KEY_FIRST  = 16'h5555;
    localparam logic [REG_W-1:0] KEY_SECOND = 16'hAAAA;

    typedef enum logic [1:0] {
        TMR_OFF  = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_FIRE = 2'd2
    } tmr_state_e;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_e;
endpackage

// File: rtl/wdog_ctrl_regs.sv
module wdog_ctrl_regs
    import wdog_pkg::*;
#(
    parameter int TW = TMO_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          ctrl_we,
    input  logic [TW-1:0] wr_tmo,
    input  logic          wr_norst,
    input  logic          wr_en,
    input  logic          wr_susp,
    input  logic          expire,
    input  logic          cause_set,
    output logic [TW-1:0] tmo,
    output logic          norst,
    output logic          en,
    output logic          susp,
    output logic          cause
);
    logic locked;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            tmo    <= '0;
            norst  <= 1'b0;
            en     <= 1'b0;
            susp   <= 1'b0;
            locked <= 1'b0;
            cause  <= 1'b0;
        end else begin
            if (ctrl_we) begin
                tmo    <= wr_tmo;
                norst  <= wr_norst;
                locked <= 1'b1;
                if (!locked) begin
                    susp <= wr_susp;
                end
                en <= en | wr_en;
            end
            if (expire) begin
                en <= 1'b0;
            end
            if (cause_set) begin
                cause <= 1'b1;
            end
        end
    end

    // R5: only an expiry may drop the enable bit
    p_enable_sticky_r5: assert property (@(posedge clk) disable iff (!por_n)
        (en && !expire) |=> en);

    // R6: once locked the suspend-permit bit never moves
    p_susp_locked_r6: assert property (@(posedge clk) disable iff (!por_n)
        locked |=> $stable(susp));

    // R9: cause flag holds until power-on reset
    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!por_n)
        cause |=> cause);
endmodule

// File: rtl/wdog_key.sv
module wdog_key
    import wdog_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         por_n,
    input  logic         svc_we,
    input  logic [W-1:0] wdata,
    output logic         reload
);
    key_state_e state, state_nx;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= KEY_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        if (svc_we) begin
            unique case (state)
                KEY_IDLE:  state_nx = (wdata == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: state_nx = (wdata == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                default:   state_nx = KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        reload = svc_we && (state == KEY_ARMED) && (wdata == KEY_SECOND);
    end

    // R3: a completed key leaves the detector idle
    p_reload_idles_r3: assert property (@(posedge clk) disable iff (!por_n)
        reload |=> (state == KEY_IDLE));

    // R4: a foreign value always disarms
    p_bad_write_idles_r4: assert property (@(posedge clk) disable iff (!por_n)
        (svc_we && wdata != KEY_FIRST && wdata != KEY_SECOND) |=> (state == KEY_IDLE));
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TW = TMO_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          tick,
    input  logic          freeze,
    input  logic          en,
    input  logic [TW-1:0] tmo,
    input  logic          norst,
    input  logic          reload,
    output logic          expire,
    output logic          cause_set,
    output logic          wd_rst
);
    tmr_state_e    state, state_nx;
    logic [TW-1:0] cnt;
    logic          expire_c;

    assign expire_c = (state == TMR_RUN) && tick && !freeze && !reload && (cnt == '0);

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state <= TMR_OFF;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TMR_OFF:  if (en) state_nx = TMR_RUN;
            TMR_RUN:  if (expire_c) state_nx = norst ? TMR_OFF : TMR_FIRE;
            TMR_FIRE: if (tick) state_nx = TMR_OFF;
            default:  state_nx = TMR_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt <= '0;
        end else if (state == TMR_OFF && en) begin
            cnt <= tmo;
        end else if (state == TMR_RUN) begin
            if (reload) begin
                cnt <= tmo;
            end else if (tick && !freeze && cnt != '0) begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    always_comb begin
        wd_rst    = (state == TMR_FIRE);
        expire    = expire_c;
        cause_set = expire_c && !norst;
    end

    // R11: a frozen countdown keeps its value
    p_freeze_holds_r11: assert property (@(posedge clk) disable iff (!por_n)
        (state == TMR_RUN && freeze && !reload) |=> $stable(cnt));

    // R8: the pulse ends at the next tick
    p_pulse_ends_r8: assert property (@(posedge clk) disable iff (!por_n)
        (wd_rst && tick) |=> !wd_rst);

    // R2: an allowed expiry raises the reset output at once
    p_fire_on_expiry_r2: assert property (@(posedge clk) disable iff (!por_n)
        (expire && !norst) |=> wd_rst);

    // R12: a suppressed expiry never fires
    p_norst_quiet_r12: assert property (@(posedge clk) disable iff (!por_n)
        (expire && norst) |=> !wd_rst);
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
    import wdog_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int AW = ADDR_W,
    parameter int TW = TMO_W
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          tick,
    input  logic          lowpower,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          wd_rst
);
    logic          ctrl_we, svc_we, reload, expire, cause_set;
    logic [TW-1:0] tmo;
    logic          norst, en, susp, cause, freeze;

    assign ctrl_we = wr_en && (addr == OFF_CTRL);
    assign svc_we  = wr_en && (addr == OFF_SVC);
    assign freeze  = susp && lowpower;

    wdog_ctrl_regs #(.TW(TW)) u_regs (
        .clk       (clk),
        .por_n     (por_n),
        .ctrl_we   (ctrl_we),
        .wr_tmo    (wdata[TMO_LSB +: TW]),
        .wr_norst  (wdata[BIT_NORST]),
        .wr_en     (wdata[BIT_EN]),
        .wr_susp   (wdata[BIT_SUSP]),
        .expire    (expire),
        .cause_set (cause_set),
        .tmo       (tmo),
        .norst     (norst),
        .en        (en),
        .susp      (susp),
        .cause     (cause)
    );

    wdog_key #(.W(DW)) u_key (
        .clk    (clk),
        .por_n  (por_n),
        .svc_we (svc_we),
        .wdata  (wdata),
        .reload (reload)
    );

    wdog_timer #(.TW(TW)) u_tmr (
        .clk       (clk),
        .por_n     (por_n),
        .tick      (tick),
        .freeze    (freeze),
        .en        (en),
        .tmo       (tmo),
        .norst     (norst),
        .reload    (reload),
        .expire    (expire),
        .cause_set (cause_set),
        .wd_rst    (wd_rst)
    );

    always_comb begin
        rdata = '0;
        unique case (addr)
            OFF_CTRL: begin
                rdata[TMO_LSB +: TW] = tmo;
                rdata[BIT_NORST]     = norst;
                rdata[BIT_EN]        = en;
                rdata[BIT_SUSP]      = susp;
            end
            OFF_STAT: rdata[BIT_CAUSE] = cause;
            default:  rdata = '0;
        endcase
    end

    // R9: a reset pulse is always accompanied by the cause flag
    p_rst_has_cause_r9: assert property (@(posedge clk) disable iff (!por_n)
        wd_rst |-> cause);
endmodule

// File: tb/wdog_keyed_test.sv
module wdog_keyed_test;
    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        tick = 1'b0;
    logic        lowpower = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [15:0] wdata = 16'h0;
    logic [15:0] rdata;
    logic        wd_rst;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    wdog_keyed uut (
        .clk(clk), .por_n(por_n), .tick(tick), .lowpower(lowpower),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata), .wd_rst(wd_rst)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        por_n = 1'b0; tick = 1'b0; lowpower = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic service();
        wr(3'd2, 16'h5555);
        wr(3'd2, 16'hAAAA);
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        rd(3'd0, v); check("R1 ctrl after reset", v, 16'h0000);
        rd(3'd4, v); check("R1 status after reset", v, 16'h0000);
        check("R1 reset output low", {15'b0, wd_rst}, 16'h0);
    endtask

    task automatic t_expiry();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 16'h0304);
        ticks(3); check("R2 no pulse after T ticks", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R2 pulse at tick T+1", {15'b0, wd_rst}, 16'h1);
        @(negedge clk); check("R8 pulse held between ticks", {15'b0, wd_rst}, 16'h1);
        ticks(1); check("R8 pulse ends at next tick", {15'b0, wd_rst}, 16'h0);
        rd(3'd4, v); check("R9 cause flag set", v, 16'h0002);
        rd(3'd0, v); check("R10 enable cleared by expiry", v, 16'h0300);
        ticks(6); check("R10 no pulse after expiry", {15'b0, wd_rst}, 16'h0);
        wr(3'd2, 16'h1111);
        rd(3'd4, v); check("R9 cause flag still set", v, 16'h0002);
    endtask

    task automatic t_service();
        do_reset();
        wr(3'd0, 16'h0304);
        ticks(3); service();
        ticks(3); check("R3 keyed pair reloads", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R3 expiry after reload", {15'b0, wd_rst}, 16'h1);
        do_reset();
        wr(3'd0, 16'h0304);
        ticks(3); wr(3'd2, 16'hAAAA); wr(3'd2, 16'h5555);
        ticks(1); check("R3 reversed keys do not reload", {15'b0, wd_rst}, 16'h1);
    endtask

    task automatic t_abort();
        do_reset();
        wr(3'd0, 16'h0304);
        ticks(3); wr(3'd2, 16'h5555); wr(3'd2, 16'h1234); wr(3'd2, 16'hAAAA);
        ticks(1); check("R4 foreign write aborts key", {15'b0, wd_rst}, 16'h1);
        do_reset();
        wr(3'd0, 16'h0304);
        ticks(3); wr(3'd2, 16'h5555); wr(3'd2, 16'h5555); wr(3'd2, 16'hAAAA);
        ticks(3); check("R4 repeated first key stays armed", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R4 expiry after armed reload", {15'b0, wd_rst}, 16'h1);
    endtask

    task automatic t_sticky();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 16'h0304);
        wr(3'd0, 16'h0300);
        rd(3'd0, v); check("R5 enable stays set", v, 16'h0304);
        ticks(3); check("R5 still counting", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R5 expiry despite clear attempt", {15'b0, wd_rst}, 16'h1);
    endtask

    task automatic t_suspend();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 16'h0001);
        rd(3'd0, v); check("R6 first write sets suspend", v, 16'h0001);
        wr(3'd0, 16'h0304);
        rd(3'd0, v); check("R6 suspend kept after later write", v, 16'h0305);
        lowpower = 1'b1;
        ticks(10); check("R11 frozen countdown", {15'b0, wd_rst}, 16'h0);
        lowpower = 1'b0;
        ticks(3); check("R11 resumed, not yet expired", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R11 expiry after resume", {15'b0, wd_rst}, 16'h1);
        do_reset();
        wr(3'd0, 16'h0304);
        wr(3'd0, 16'h0305);
        rd(3'd0, v); check("R6 later write cannot set suspend", v, 16'h0304);
        lowpower = 1'b1;
        ticks(4); check("R11 lowpower ignored without permit", {15'b0, wd_rst}, 16'h1);
        lowpower = 1'b0;
    endtask

    task automatic t_deferred();
        do_reset();
        wr(3'd0, 16'h0304);
        ticks(2); wr(3'd0, 16'h0704);
        ticks(1); check("R7 old count continues", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R7 expiry on old value", {15'b0, wd_rst}, 16'h1);
        do_reset();
        wr(3'd0, 16'h0304);
        wr(3'd0, 16'h0704); service();
        ticks(7); check("R7 new value used after reload", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R7 expiry at new length", {15'b0, wd_rst}, 16'h1);
    endtask

    task automatic t_norst();
        logic [15:0] v;
        do_reset();
        wr(3'd0, 16'h010C);
        ticks(1); check("R12 counting", {15'b0, wd_rst}, 16'h0);
        ticks(1); check("R12 no pulse on expiry", {15'b0, wd_rst}, 16'h0);
        rd(3'd4, v); check("R12 no cause flag", v, 16'h0000);
        rd(3'd0, v); check("R12 enable cleared", v, 16'h0108);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_expiry();
        t_service();
        t_abort();
        t_sticky();
        t_suspend();
        t_deferred();
        t_norst();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule